// File: doc/BRIEF.md
# Sized-Access CPU Register File

This block is the integer register file of a processor core. It keeps eight 32-bit data registers, seven 32-bit address registers and two stack pointers. One stack pointer is for user mode and one is for supervisor mode. A mode input decides which stack pointer answers as the eighth address register. Software only ever sees that active copy. The other copy keeps its value until the mode returns to it.

The file has two independent read ports and one write port. Every access carries a size: byte, word or long.
- A narrow write to a data register replaces only the low-order field and keeps the upper bits as they were.
- A narrow write to an address register is sign-extended, so the full 32 bits always change.
- Reads are combinational and return the selected register formatted to the size asked for.
- Writes take effect at the rising clock edge.

Top module: `sized_regfile`

## Requirements
- R1: After reset, every register, including both stack pointer copies, reads as zero at every index and in both modes.
- R2: A 4-bit register index selects the register. Bit 3 clear selects data register bits[2:0]. Bit 3 set selects address register bits[2:0]. Index 15 selects the active stack pointer.
- R3: A write to a data register at byte size replaces bits 7:0, and at word size replaces bits 15:0. In both cases all higher bits are kept. At long size all 32 bits are replaced.
- R4: A write to an address register always replaces all 32 bits. A byte write stores wr_data[7:0] sign-extended, a word write stores wr_data[15:0] sign-extended, and a long write stores wr_data.
- R5: Size codes are 2'b00 byte, 2'b01 word and 2'b10 long. Code 2'b11 behaves exactly as long, for writes and for reads.
- R6: Each read port returns the selected register as follows: at byte size, bits 7:0 zero-extended; at word size, bits 15:0 zero-extended; at long size, all 32 bits. The two ports are independent.
- R7: With sup_mode low, index 15 reads and writes the user stack pointer. With sup_mode high, it reads and writes the supervisor stack pointer. Changing sup_mode alters neither stored value.
- R8: A read of the register being written in the same cycle returns the value held before the write. The new value is visible after the rising clock edge.
- R9: With wr_en low, no register changes. A write changes only the register it selects.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| sup_mode | input | 1 | High selects the supervisor stack pointer for index 15 |
| wr_en | input | 1 | Write enable |
| wr_idx | input | 4 | Write register index |
| wr_size | input | 2 | Write size code |
| wr_data | input | 32 | Write data, low-aligned |
| rd_a_idx | input | 4 | Read port A register index |
| rd_a_size | input | 2 | Read port A size code |
| rd_a_data | output | 32 | Read port A data |
| rd_b_idx | input | 4 | Read port B register index |
| rd_b_size | input | 2 | Read port B size code |
| rd_b_data | output | 32 | Read port B data |

## Verification
A read and a write can fall in the same cycle and select the same register. The merge of old and new bits must then stay invisible to the reader until the edge. The bench provokes this on every write in a sweep that covers all indices, all four size codes and both modes. Port A points at the write target while the write is pending. Port A must show the old value before the rising edge and the merged value after it. Each write is then followed by a read-back of all sixteen indices in both modes, which judges that the other bank copy and every other register were left alone.

// File: rtl/rf_pkg.sv
package rf_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_WORD = 2'b01,
    SZ_LONG = 2'b10,
    SZ_LALT = 2'b11
  } size_e;

  localparam int BYTE_W = 8;
  localparam int WORD_W = 16;
endpackage

// File: rtl/rf_reset_sync.sv
module rf_reset_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] shift_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) shift_q <= '0;
    else        shift_q <= {shift_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = shift_q[STAGES-1];
endmodule

// File: rtl/rf_write_merge.sv
module rf_write_merge
  import rf_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic [XLEN-1:0] old_val,
  input  logic [XLEN-1:0] wr_data,
  input  logic [1:0]      size,
  input  logic            is_addr,
  output logic [XLEN-1:0] new_val
);
  always_comb begin
    case (size)
      SZ_BYTE: new_val = is_addr
                         ? {{(XLEN-BYTE_W){wr_data[BYTE_W-1]}}, wr_data[BYTE_W-1:0]}
                         : {old_val[XLEN-1:BYTE_W], wr_data[BYTE_W-1:0]};
      SZ_WORD: new_val = is_addr
                         ? {{(XLEN-WORD_W){wr_data[WORD_W-1]}}, wr_data[WORD_W-1:0]}
                         : {old_val[XLEN-1:WORD_W], wr_data[WORD_W-1:0]};
      default: new_val = wr_data;
    endcase
  end
endmodule

// File: rtl/rf_read_size.sv
module rf_read_size
  import rf_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic [XLEN-1:0] raw,
  input  logic [1:0]      size,
  output logic [XLEN-1:0] data
);
  always_comb begin
    case (size)
      SZ_BYTE: data = {{(XLEN-BYTE_W){1'b0}}, raw[BYTE_W-1:0]};
      SZ_WORD: data = {{(XLEN-WORD_W){1'b0}}, raw[WORD_W-1:0]};
      default: data = raw;
    endcase
  end
endmodule

// File: rtl/sized_regfile.sv
module sized_regfile #(
  parameter int XLEN  = 32,
  parameter int SEL_W = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                sup_mode,
  input  logic                wr_en,
  input  logic [SEL_W:0]      wr_idx,
  input  logic [1:0]          wr_size,
  input  logic [XLEN-1:0]     wr_data,
  input  logic [SEL_W:0]      rd_a_idx,
  input  logic [1:0]          rd_a_size,
  output logic [XLEN-1:0]     rd_a_data,
  input  logic [SEL_W:0]      rd_b_idx,
  input  logic [1:0]          rd_b_size,
  output logic [XLEN-1:0]     rd_b_data
);
  localparam int NREG     = 2 ** SEL_W;
  localparam int IDX_W    = SEL_W + 1;
  localparam int NSLOT    = 2 * NREG + 1;
  localparam int SLOT_W   = $clog2(NSLOT);
  localparam int USP_SLOT = 2 * NREG - 1;
  localparam int SSP_SLOT = 2 * NREG;
  localparam int NPORT    = 2;

  // Slots: data regs, general address regs, user SP, supervisor SP.
  function automatic logic [SLOT_W-1:0] map_slot(input logic [IDX_W-1:0] idx,
                                                 input logic sup);
    if (&idx) return sup ? SLOT_W'(SSP_SLOT) : SLOT_W'(USP_SLOT);
    return SLOT_W'(idx);
  endfunction

  logic                        rst_sync_n;
  logic [NSLOT-1:0][XLEN-1:0]  slot_q;
  logic [NSLOT-1:0]            slot_en;
  logic [SLOT_W-1:0]           wr_slot;
  logic [XLEN-1:0]             merged;

  rf_reset_sync #(.STAGES(2)) u_rst (
    .clk       (clk),
    .rst_n     (rst_n),
    .rst_sync_n(rst_sync_n)
  );

  assign wr_slot = map_slot(wr_idx, sup_mode);

  rf_write_merge #(.XLEN(XLEN)) u_merge (
    .old_val(slot_q[wr_slot]),
    .wr_data(wr_data),
    .size   (wr_size),
    .is_addr(wr_idx[IDX_W-1]),
    .new_val(merged)
  );

  // Next-state: per-slot clock enable.
  always_comb begin
    for (int s = 0; s < NSLOT; s++) begin
      slot_en[s] = wr_en && (wr_slot == SLOT_W'(s));
    end
  end

  // Register process.
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      slot_q <= '0;
    end else begin
      for (int s = 0; s < NSLOT; s++) begin
        if (slot_en[s]) slot_q[s] <= merged;
      end
    end
  end

  // Read ports.
  logic [NPORT-1:0][IDX_W-1:0] rd_idx;
  logic [NPORT-1:0][1:0]       rd_size;
  logic [NPORT-1:0][XLEN-1:0]  rd_out;

  assign rd_idx[0]  = rd_a_idx;
  assign rd_idx[1]  = rd_b_idx;
  assign rd_size[0] = rd_a_size;
  assign rd_size[1] = rd_b_size;

  for (genvar p = 0; p < NPORT; p++) begin : g_rd
    logic [SLOT_W-1:0] rd_slot;
    assign rd_slot = map_slot(rd_idx[p], sup_mode);
    rf_read_size #(.XLEN(XLEN)) u_fmt (
      .raw (slot_q[rd_slot]),
      .size(rd_size[p]),
      .data(rd_out[p])
    );
  end

  assign rd_a_data = rd_out[0];
  assign rd_b_data = rd_out[1];
endmodule

// File: rtl/rf_checker.sv
module rf_checker
  import rf_pkg::*;
#(
  parameter int XLEN  = 32,
  parameter int SEL_W = 3
) (
  input logic                                clk,
  input logic                                rst_sync_n,
  input logic                                sup_mode,
  input logic                                wr_en,
  input logic [SEL_W:0]                      wr_idx,
  input logic [1:0]                          wr_size,
  input logic [XLEN-1:0]                     wr_data,
  input logic [1:0]                          rd_a_size,
  input logic [XLEN-1:0]                     rd_a_data,
  input logic [1:0]                          rd_b_size,
  input logic [XLEN-1:0]                     rd_b_data,
  input logic [2*(2**SEL_W):0][XLEN-1:0]     slot_q
);
  localparam int NREG     = 2 ** SEL_W;
  localparam int NSLOT    = 2 * NREG + 1;
  localparam int SLOT_W   = $clog2(NSLOT);
  localparam int USP_SLOT = 2 * NREG - 1;
  localparam int SSP_SLOT = 2 * NREG;

  logic [SLOT_W-1:0]          tgt;
  logic [NSLOT-1:0][XLEN-1:0] prev_q;
  logic [SLOT_W-1:0]          prev_tgt;
  logic                       prev_valid, prev_en, prev_addr, prev_bank, prev_sup;
  logic [1:0]                 prev_size;
  logic [XLEN-1:0]            prev_data;

  always_comb begin
    if (&wr_idx) tgt = sup_mode ? SLOT_W'(SSP_SLOT) : SLOT_W'(USP_SLOT);
    else         tgt = SLOT_W'(wr_idx);
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      prev_valid <= 1'b0;
      prev_q     <= '0;
      prev_tgt   <= '0;
      prev_en    <= 1'b0;
      prev_addr  <= 1'b0;
      prev_bank  <= 1'b0;
      prev_sup   <= 1'b0;
      prev_size  <= '0;
      prev_data  <= '0;
    end else begin
      prev_valid <= 1'b1;
      prev_q     <= slot_q;
      prev_tgt   <= tgt;
      prev_en    <= wr_en;
      prev_addr  <= wr_idx[SEL_W];
      prev_bank  <= &wr_idx;
      prev_sup   <= sup_mode;
      prev_size  <= wr_size;
      prev_data  <= wr_data;
    end
  end

  assert_data_byte_keeps_upper_R3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (prev_valid && prev_en && !prev_addr && prev_size == SZ_BYTE) |->
      (slot_q[prev_tgt] == {prev_q[prev_tgt][XLEN-1:8], prev_data[7:0]}));

  assert_data_word_keeps_upper_R3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (prev_valid && prev_en && !prev_addr && prev_size == SZ_WORD) |->
      (slot_q[prev_tgt] == {prev_q[prev_tgt][XLEN-1:16], prev_data[15:0]}));

  assert_addr_word_sext_R4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (prev_valid && prev_en && prev_addr && prev_size == SZ_WORD) |->
      (slot_q[prev_tgt] == {{(XLEN-16){prev_data[15]}}, prev_data[15:0]}));

  assert_bank_other_kept_R7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (prev_valid && prev_en && prev_bank) |->
      (prev_sup ? (slot_q[USP_SLOT] == prev_q[USP_SLOT])
                : (slot_q[SSP_SLOT] == prev_q[SSP_SLOT])));

  assert_rd_a_byte_zext_R6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (rd_a_size == SZ_BYTE) |-> (rd_a_data[XLEN-1:8] == '0));

  assert_rd_b_word_zext_R6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (rd_b_size == SZ_WORD) |-> (rd_b_data[XLEN-1:16] == '0));

  for (genvar s = 0; s < NSLOT; s++) begin : g_stable
    assert_untouched_stable_R9: assert property (@(posedge clk) disable iff (!rst_sync_n)
      (prev_valid && !(prev_en && prev_tgt == SLOT_W'(s))) |-> (slot_q[s] == prev_q[s]));
  end
endmodule

bind sized_regfile rf_checker #(.XLEN(XLEN), .SEL_W(SEL_W)) u_chk (
  .clk       (clk),
  .rst_sync_n(rst_sync_n),
  .sup_mode  (sup_mode),
  .wr_en     (wr_en),
  .wr_idx    (wr_idx),
  .wr_size   (wr_size),
  .wr_data   (wr_data),
  .rd_a_size (rd_a_size),
  .rd_a_data (rd_a_data),
  .rd_b_size (rd_b_size),
  .rd_b_data (rd_b_data),
  .slot_q    (slot_q)
);

// File: tb/tb_sized_regfile.sv
`timescale 1ns/1ps
module tb_sized_regfile;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        sup_mode;
  logic        wr_en;
  logic [3:0]  wr_idx;
  logic [1:0]  wr_size;
  logic [31:0] wr_data;
  logic [3:0]  rd_a_idx, rd_b_idx;
  logic [1:0]  rd_a_size, rd_b_size;
  logic [31:0] rd_a_data, rd_b_data;

  int checks = 0;
  int errors = 0;
  bit done   = 0;
  logic [31:0] model [17];

  always #2 clk = ~clk;

  sized_regfile dut (
    .clk(clk), .rst_n(rst_n), .sup_mode(sup_mode),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_size(wr_size), .wr_data(wr_data),
    .rd_a_idx(rd_a_idx), .rd_a_size(rd_a_size), .rd_a_data(rd_a_data),
    .rd_b_idx(rd_b_idx), .rd_b_size(rd_b_size), .rd_b_data(rd_b_data)
  );

  // R2 / R7: index 15 maps to slot 15 (user) or 16 (supervisor).
  function automatic int slot_of(input logic [3:0] idx, input logic sup);
    if (idx == 4'hF) return sup ? 16 : 15;
    return int'(idx);
  endfunction

  // R3 / R4 / R5 expected write result.
  function automatic logic [31:0] exp_write(input logic [31:0] old, input logic [31:0] d,
                                            input logic [1:0] sz, input logic is_addr);
    if (sz == 2'd0) return is_addr ? 32'(signed'(d[7:0])) : ((old & 32'hFFFF_FF00) | {24'd0, d[7:0]});
    if (sz == 2'd1) return is_addr ? 32'(signed'(d[15:0])) : ((old & 32'hFFFF_0000) | {16'd0, d[15:0]});
    return d;
  endfunction

  // R6 expected read format.
  function automatic logic [31:0] exp_read(input logic [31:0] v, input logic [1:0] sz);
    if (sz == 2'd0) return v % 32'd256;
    if (sz == 2'd1) return v % 32'd65536;
    return v;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic read_all(input string tag, input int bsz);
    for (int m = 0; m < 2; m++) begin
      sup_mode = m[0];
      for (int i = 0; i < 16; i++) begin
        rd_a_idx = i[3:0]; rd_a_size = 2'd2;
        rd_b_idx = i[3:0]; rd_b_size = bsz[1:0];
        #0.2;
        check(tag, rd_a_data, model[slot_of(i[3:0], m[0])]);
        check({tag, " R6 port B"}, rd_b_data, exp_read(model[slot_of(i[3:0], m[0])], bsz[1:0]));
      end
    end
  endtask

  // Starts and ends at a falling edge.
  task automatic do_write(input logic [3:0] idx, input logic [1:0] sz, input logic [31:0] d,
                          input logic sup, input logic en);
    int sl;
    sl = slot_of(idx, sup);
    sup_mode = sup; wr_idx = idx; wr_size = sz; wr_data = d; wr_en = en;
    rd_a_idx = idx; rd_a_size = 2'd2;
    #0.5;
    check("R8 old value before edge", rd_a_data, model[sl]);
    @(posedge clk);
    if (en) model[sl] = exp_write(model[sl], d, sz, idx[3]);
    @(negedge clk);
    wr_en = 1'b0;
    #0.5;
    check(sz == 2'd3 ? "R5 size 11 as long" : (idx[3] ? "R4 address write" : "R3 data write"),
          rd_a_data, model[sl]);
  endtask

  initial begin
    int k;
    for (int s = 0; s < 17; s++) model[s] = 32'd0;
    rst_n = 1'b0; sup_mode = 1'b0; wr_en = 1'b0; wr_idx = '0; wr_size = '0; wr_data = '0;
    rd_a_idx = '0; rd_b_idx = '0; rd_a_size = 2'd2; rd_b_size = 2'd2;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    read_all("R1 reset zero", 2);
    @(negedge clk);

    k = 0;
    for (int m = 0; m < 2; m++) begin
      for (int i = 0; i < 16; i++) begin
        for (int z = 0; z < 4; z++) begin
          k++;
          do_write(i[3:0], z[1:0], 32'h9E37_79B9 * k, m[0], 1'b1);
          read_all("R9 R7 R2 sweep readback", k % 3);
          @(negedge clk);
        end
      end
    end

    // Writes with enable low must leave every register unchanged.
    for (int i = 0; i < 16; i += 5) begin
      do_write(i[3:0], 2'd2, 32'hDEAD_BEEF ^ i, 1'b0, 1'b0);
      read_all("R9 disabled write", 1);
      @(negedge clk);
    end

    // Bank switching alone changes no value.
    do_write(4'hF, 2'd2, 32'h1111_2222, 1'b0, 1'b1);
    @(negedge clk);
    do_write(4'hF, 2'd2, 32'h3333_4444, 1'b1, 1'b1);
    @(negedge clk);
    for (int t = 0; t < 4; t++) begin
      sup_mode = t[0];
      rd_a_idx = 4'hF; rd_a_size = 2'd2;
      @(negedge clk);
      check("R7 bank select", rd_a_data, t[0] ? 32'h3333_4444 : 32'h1111_2222);
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule